// File: doc/BRIEF.md
# Serial Memory Dump Responder

This block is the device-side protocol engine of a command-driven memory dump link. The link is full duplex and works one byte at a time. Each byte the host sends is paired with one byte the device sends back. The serial shifter itself lies outside the block. The block sees a one-cycle strobe carrying the received byte. It presents the reply for that exchange on `tx_byte` from the following cycle and holds it until the next strobe.

Three commands are decoded:

- **Addressed read.** This command is acknowledged, then takes a 32-bit start address over four exchanges. After that it returns a fixed number of memory bytes. For those data exchanges the host must send a descending count, and the device checks each count byte.
- **Wide fixed dump and narrow fixed dump.** These two commands need no address. Each streams a fixed region from a base that is set by parameter, and the bytes the host sends during them are ignored.

Memory is read through a synchronous port that returns data one cycle after the read strobe. Each byte is fetched ahead of the exchange that returns it.

Top module: `dump_responder`

## Requirements
- R1: In idle, a received A3h makes the next `tx_byte` E0h, raises `busy` and clears `err`; F3h and F4h also clear `err`.
- R2: After A3h, the next four exchanges carry the start address, least significant byte first, and each of them replies 00h.
- R3: After the fourth address byte, exactly one memory read is made at that address before the next exchange, and the first data exchange returns that byte.
- R4: Each further data exchange returns the byte at the previous address plus one. `tx_byte` changes only in the cycle after a `rx_valid` strobe.
- R5: In the addressed read, the host count bytes must run from READ_LEN (80h by default) down to 01h. After the exchange carrying 01h, `busy` falls.
- R6: A count byte that differs from the expected one replies FFh, sets `err`, returns to idle and causes no further memory read.
- R7: F3h replies E0h and streams BIG_LEN bytes (131072 by default) from BIG_BASE (default 0). Host bytes are ignored, and `busy` falls after the last byte.
- R8: F4h replies E0h and streams SMALL_LEN bytes (32768 by default) from SMALL_BASE (default A0000000h). Host bytes are ignored, and `busy` falls after the last byte.
- R9: Any other command byte in idle replies FFh, leaves `busy` low and leaves `err` unchanged.
- R10: While reset is held, `tx_byte` is 00h and `busy`, `err` and `mem_rd` are 0.
- R11: `mem_rd` is a single-cycle pulse and is asserted only while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | One-cycle strobe marking a completed exchange |
| rx_byte | input | 8 | Byte received from the host in that exchange |
| tx_byte | output | 8 | Reply byte for the most recent exchange |
| mem_addr | output | 32 | Memory read address |
| mem_rd | output | 1 | Memory read strobe; data is expected on the next cycle |
| mem_rdata | input | 8 | Memory read data |
| busy | output | 1 | A command is in progress |
| err | output | 1 | The last addressed read was aborted by a count mismatch |

## Verification
Every command value is driven from idle, both recognised and unrecognised, so that the acknowledge, rejection and busy decisions can be told apart. A full addressed read with a correct descending count shows the little-endian address assembly and the per-byte increment. A second addressed read near the top of the address space breaks the count partway through, which separates an abort from a normal end and shows that reads stop. The two fixed dumps are fed arbitrary host bytes, which shows that those bytes are ignored and that each region has the right base and length.

// File: rtl/dump_pkg.sv
package dump_pkg;

    localparam int ADDR_W = 32;
    localparam int BYTE_W = 8;

    localparam logic [7:0] CMD_ADDR_READ = 8'hA3;
    localparam logic [7:0] CMD_WIDE      = 8'hF3;
    localparam logic [7:0] CMD_NARROW    = 8'hF4;
    localparam logic [7:0] REPLY_ACK     = 8'hE0;
    localparam logic [7:0] REPLY_NAK     = 8'hFF;
    localparam logic [7:0] REPLY_FILL    = 8'h00;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_FETCH,
        ST_CAPT,
        ST_STREAM
    } state_e;

    typedef struct packed {
        logic              known;
        logic              addressed;
        logic [ADDR_W-1:0] base;
    } cmd_info_t;

    // Counter width able to hold the largest length, never below one byte.
    function automatic int count_width(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
        int unsigned m;
        int w;
        m = (a > b) ? a : b;
        m = (m > c) ? m : c;
        w = $clog2(m + 1);
        return (w < BYTE_W) ? BYTE_W : w;
    endfunction

endpackage

// File: rtl/dump_cmd_decode.sv
module dump_cmd_decode
    import dump_pkg::*;
#(
    parameter int unsigned              READ_LEN   = 128,
    parameter int unsigned              BIG_LEN    = 131072,
    parameter int unsigned              SMALL_LEN  = 32768,
    parameter logic [dump_pkg::ADDR_W-1:0] BIG_BASE   = '0,
    parameter logic [dump_pkg::ADDR_W-1:0] SMALL_BASE = 32'hA000_0000,
    parameter int                       CW         = 18
) (
    input  logic [7:0]    cmd,
    output cmd_info_t     info,
    output logic [CW-1:0] len
);

    always_comb begin
        info = '{known: 1'b0, addressed: 1'b0, base: '0};
        len  = '0;
        unique case (cmd)
            CMD_ADDR_READ: begin
                info.known     = 1'b1;
                info.addressed = 1'b1;
                len            = CW'(READ_LEN);
            end
            CMD_WIDE: begin
                info.known = 1'b1;
                info.base  = BIG_BASE;
                len        = CW'(BIG_LEN);
            end
            CMD_NARROW: begin
                info.known = 1'b1;
                info.base  = SMALL_BASE;
                len        = CW'(SMALL_LEN);
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/dump_addr_ptr.sv
module dump_addr_ptr
    import dump_pkg::*;
#(
    parameter int AW    = dump_pkg::ADDR_W,
    parameter int LANES = AW / 8,
    parameter int IW    = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          lane_we,
    input  logic [IW-1:0] lane_sel,
    input  logic [7:0]    lane_data,
    input  logic          base_we,
    input  logic [AW-1:0] base_val,
    input  logic          inc,
    output logic [AW-1:0] ptr
);

    logic [AW-1:0] ptr_inc;
    logic [7:0]    lane_q [LANES];

    assign ptr_inc = ptr + AW'(1);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst) begin
                lane_q[g] <= '0;
            end else if (base_we) begin
                lane_q[g] <= base_val[g*8 +: 8];
            end else if (inc) begin
                lane_q[g] <= ptr_inc[g*8 +: 8];
            end else if (lane_we && (lane_sel == IW'(g))) begin
                lane_q[g] <= lane_data;
            end
        end
        assign ptr[g*8 +: 8] = lane_q[g];
    end

endmodule

// File: rtl/dump_fetch_buf.sv
module dump_fetch_buf #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          capture,
    input  logic [DW-1:0] rdata,
    output logic [DW-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (capture) begin
            q <= rdata;
        end
    end

endmodule

// File: rtl/dump_responder.sv
module dump_responder
    import dump_pkg::*;
#(
    parameter int unsigned                 READ_LEN   = 128,
    parameter int unsigned                 BIG_LEN    = 131072,
    parameter int unsigned                 SMALL_LEN  = 32768,
    parameter logic [dump_pkg::ADDR_W-1:0] BIG_BASE   = '0,
    parameter logic [dump_pkg::ADDR_W-1:0] SMALL_BASE = 32'hA000_0000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        rx_valid,
    input  logic [7:0]  rx_byte,
    output logic [7:0]  tx_byte,
    output logic [31:0] mem_addr,
    output logic        mem_rd,
    input  logic [7:0]  mem_rdata,
    output logic        busy,
    output logic        err
);

    localparam int CW    = count_width(READ_LEN, BIG_LEN, SMALL_LEN);
    localparam int LANES = ADDR_W / BYTE_W;
    localparam int IW    = $clog2(LANES);

    state_e        state;
    cmd_info_t     info;
    logic [CW-1:0] cmd_len;
    logic [CW-1:0] remain;
    logic [IW-1:0] lane_idx;
    logic          addressed;
    logic [7:0]    buf_q;
    logic          count_ok;
    logic          accept_data;

    dump_cmd_decode #(
        .READ_LEN  (READ_LEN),
        .BIG_LEN   (BIG_LEN),
        .SMALL_LEN (SMALL_LEN),
        .BIG_BASE  (BIG_BASE),
        .SMALL_BASE(SMALL_BASE),
        .CW        (CW)
    ) i_decode (
        .cmd (rx_byte),
        .info(info),
        .len (cmd_len)
    );

    // In the addressed read the host count must equal the bytes still owed.
    assign count_ok    = !addressed || (rx_byte == remain[7:0]);
    assign accept_data = (state == ST_STREAM) && rx_valid && count_ok;

    dump_addr_ptr #(
        .AW   (ADDR_W),
        .LANES(LANES),
        .IW   (IW)
    ) i_ptr (
        .clk      (clk),
        .rst      (rst),
        .lane_we  ((state == ST_ADDR) && rx_valid),
        .lane_sel (lane_idx),
        .lane_data(rx_byte),
        .base_we  ((state == ST_IDLE) && rx_valid && info.known && !info.addressed),
        .base_val (info.base),
        .inc      (accept_data),
        .ptr      (mem_addr)
    );

    dump_fetch_buf #(
        .DW(BYTE_W)
    ) i_buf (
        .clk    (clk),
        .rst    (rst),
        .capture(state == ST_CAPT),
        .rdata  (mem_rdata),
        .q      (buf_q)
    );

    assign mem_rd = (state == ST_FETCH);
    assign busy   = (state != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            tx_byte   <= REPLY_FILL;
            err       <= 1'b0;
            remain    <= '0;
            lane_idx  <= '0;
            addressed <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (rx_valid) begin
                        if (info.known) begin
                            tx_byte   <= REPLY_ACK;
                            err       <= 1'b0;
                            remain    <= cmd_len;
                            addressed <= info.addressed;
                            lane_idx  <= '0;
                            state     <= info.addressed ? ST_ADDR : ST_FETCH;
                        end else begin
                            tx_byte <= REPLY_NAK;
                        end
                    end
                end
                ST_ADDR: begin
                    if (rx_valid) begin
                        tx_byte  <= REPLY_FILL;
                        lane_idx <= lane_idx + IW'(1);
                        if (lane_idx == IW'(LANES - 1)) begin
                            state <= ST_FETCH;
                        end
                    end
                end
                ST_FETCH: state <= ST_CAPT;
                ST_CAPT:  state <= ST_STREAM;
                ST_STREAM: begin
                    if (rx_valid) begin
                        if (!count_ok) begin
                            tx_byte <= REPLY_NAK;
                            err     <= 1'b1;
                            state   <= ST_IDLE;
                        end else begin
                            tx_byte <= buf_q;
                            remain  <= remain - CW'(1);
                            state   <= (remain == CW'(1)) ? ST_IDLE : ST_FETCH;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/dump_responder_chk.sv
module dump_responder_chk
    import dump_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       rx_valid,
    input logic [7:0] rx_byte,
    input logic [7:0] tx_byte,
    input logic       mem_rd,
    input logic       busy,
    input logic       err
);

    logic known_cmd;
    assign known_cmd = (rx_byte == CMD_ADDR_READ) || (rx_byte == CMD_WIDE) ||
                       (rx_byte == CMD_NARROW);

    p_ack_r1: assert property (@(posedge clk) disable iff (rst)
        !busy && rx_valid && (rx_byte == CMD_ADDR_READ) |=>
            (tx_byte == REPLY_ACK) && busy && !err);

    p_reply_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !rx_valid |=> $stable(tx_byte));

    p_abort_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(err) |-> !busy && (tx_byte == REPLY_NAK));

    p_wide_ack_r7: assert property (@(posedge clk) disable iff (rst)
        !busy && rx_valid && (rx_byte == CMD_WIDE) |=> (tx_byte == REPLY_ACK) && busy);

    p_narrow_ack_r8: assert property (@(posedge clk) disable iff (rst)
        !busy && rx_valid && (rx_byte == CMD_NARROW) |=> (tx_byte == REPLY_ACK) && busy);

    p_unknown_r9: assert property (@(posedge clk) disable iff (rst)
        !busy && rx_valid && !known_cmd |=>
            (tx_byte == REPLY_NAK) && !busy && $stable(err));

    p_rd_busy_r11: assert property (@(posedge clk) disable iff (rst)
        mem_rd |-> busy);

    p_rd_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        mem_rd |=> !mem_rd);

endmodule

bind dump_responder dump_responder_chk i_chk (
    .clk     (clk),
    .rst     (rst),
    .rx_valid(rx_valid),
    .rx_byte (rx_byte),
    .tx_byte (tx_byte),
    .mem_rd  (mem_rd),
    .busy    (busy),
    .err     (err)
);

// File: tb/test_dump_responder.sv
module test_dump_responder;

    localparam int unsigned READ_LEN   = 128;
    localparam int unsigned BIG_LEN    = 20;
    localparam int unsigned SMALL_LEN  = 12;
    localparam logic [31:0] BIG_BASE   = 32'h0000_0000;
    localparam logic [31:0] SMALL_BASE = 32'hA000_0000;

    // command, expected reply, expected busy
    localparam int NVEC = 8;
    localparam logic [16:0] VEC [NVEC] = '{
        {8'hA3, 8'hE0, 1'b1},
        {8'hF3, 8'hE0, 1'b1},
        {8'hF4, 8'hE0, 1'b1},
        {8'h00, 8'hFF, 1'b0},
        {8'hA2, 8'hFF, 1'b0},
        {8'hF5, 8'hFF, 1'b0},
        {8'hE0, 8'hFF, 1'b0},
        {8'hFF, 8'hFF, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = 8'h00;
    logic [7:0]  tx_byte;
    logic [31:0] mem_addr;
    logic        mem_rd;
    logic [7:0]  mem_rdata = 8'h00;
    logic        busy;
    logic        err;

    int checks = 0;
    int fails  = 0;
    int rd_count = 0;
    int rd_viol  = 0;
    logic prev_rd = 1'b0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dump_responder #(
        .READ_LEN  (READ_LEN),
        .BIG_LEN   (BIG_LEN),
        .SMALL_LEN (SMALL_LEN),
        .BIG_BASE  (BIG_BASE),
        .SMALL_BASE(SMALL_BASE)
    ) i_dump_responder (
        .clk      (clk),
        .rst      (rst),
        .rx_valid (rx_valid),
        .rx_byte  (rx_byte),
        .tx_byte  (tx_byte),
        .mem_addr (mem_addr),
        .mem_rd   (mem_rd),
        .mem_rdata(mem_rdata),
        .busy     (busy),
        .err      (err)
    );

    function automatic logic [7:0] mem_fn(input logic [31:0] a);
        return a[7:0] ^ {a[12:8], a[15:13]} ^ a[23:16] ^ a[31:24] ^ 8'h3C;
    endfunction

    // Synchronous memory model: data one cycle after the read strobe.
    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= mem_fn(mem_addr);
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (mem_rd) rd_count++;
            if (mem_rd && !busy) rd_viol++;
            if (mem_rd && prev_rd) rd_viol++;
            prev_rd = mem_rd;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic xchg(input logic [7:0] b, output logic [7:0] r);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_byte  = b;
        @(negedge clk);
        rx_valid = 1'b0;
        r = tx_byte;
        repeat (3) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic send_addr(input logic [31:0] a);
        logic [7:0] r;
        for (int k = 0; k < 4; k++) begin
            xchg(a[k*8 +: 8], r);
            chk("R2 address byte reply", r, 8'h00);
        end
    endtask

    task automatic fixed_dump(input string req, input logic [7:0] cmd,
                              input logic [31:0] base, input int n);
        logic [7:0] r;
        xchg(cmd, r);
        chk(req, r, 8'hE0);
        chk(req, err, 1'b0);
        for (int i = 0; i < n; i++) begin
            xchg(8'(i * 37 + 5), r);
            chk(req, r, mem_fn(base + 32'(i)));
        end
        chk(req, busy, 1'b0);
    endtask

    initial begin
        logic [7:0] r;
        logic [31:0] a;
        int rd_snap;

        // R10: state while reset is held
        repeat (2) @(negedge clk);
        chk("R10 tx_byte in reset", tx_byte, 8'h00);
        chk("R10 busy in reset", busy, 1'b0);
        chk("R10 err in reset", err, 1'b0);
        chk("R10 mem_rd in reset", mem_rd, 1'b0);
        rst = 1'b0;

        // R1 R7 R8 R9: command decode from idle
        for (int v = 0; v < NVEC; v++) begin
            do_reset();
            xchg(VEC[v][16:9], r);
            chk("R1/R9 command reply", r, VEC[v][8:1]);
            chk("R1/R9 command busy", busy, VEC[v][0]);
        end

        // R1 R2 R3 R4 R5: full addressed read
        do_reset();
        a = 32'h1234_5678;
        xchg(8'hA3, r);
        chk("R1 ack", r, 8'hE0);
        chk("R1 busy", busy, 1'b1);
        send_addr(a);
        for (int k = READ_LEN; k >= 1; k--) begin
            xchg(8'(k), r);
            if (k == READ_LEN) chk("R3 first data byte", r, mem_fn(a));
            else chk("R4 data byte", r, mem_fn(a + 32'(READ_LEN - k)));
        end
        chk("R4 reply held between exchanges", tx_byte, mem_fn(a + 32'(READ_LEN - 1)));
        chk("R5 idle after last count", busy, 1'b0);
        chk("R5 no error", err, 1'b0);

        // R6: count mismatch near the top of the address space
        a = 32'hFFFF_FFF0;
        xchg(8'hA3, r);
        send_addr(a);
        xchg(8'h80, r);
        chk("R3 first byte high addr", r, mem_fn(a));
        xchg(8'h7F, r);
        chk("R4 second byte high addr", r, mem_fn(a + 1));
        xchg(8'h55, r);
        rd_snap = rd_count;
        chk("R6 mismatch reply", r, 8'hFF);
        chk("R6 err set", err, 1'b1);
        chk("R6 idle", busy, 1'b0);
        repeat (10) @(negedge clk);
        chk("R6 no read after abort", rd_count, rd_snap);

        // R9: unknown command keeps err
        xchg(8'h12, r);
        chk("R9 unknown reply", r, 8'hFF);
        chk("R9 err unchanged", err, 1'b1);
        chk("R9 idle", busy, 1'b0);

        // R8 then R7: fixed dumps, host bytes ignored
        fixed_dump("R8 narrow dump", 8'hF4, SMALL_BASE, SMALL_LEN);
        fixed_dump("R7 wide dump", 8'hF3, BIG_BASE, BIG_LEN);

        // R11: read strobe shape over the whole run
        chk("R11 read pulse violations", rd_viol, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog (all R) actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule